// File: doc/BRIEF.md
# Offset and gain result corrector

This block sits right after a sample converter and corrects each raw sample for offset and gain in digital logic. Two calibration codes set the correction. Each code is a 14-bit data field, and a register bank elsewhere holds both codes steady. The offset code is centred on 0x2000, where it adds nothing. One offset code step is worth 0.05 of full scale divided by 2^13, so the full code range covers about ±5% of full scale. The gain code is also centred on 0x2000. It sets a multiplier near one, anywhere from 0.975 to 1.025.

Each valid sample first has the offset correction added. The sum is then multiplied by the gain factor, rounded to the nearest output step and clamped to the unsigned output range. The result appears two clock cycles after the sample, together with its own valid flag. When no valid sample arrives, the output register keeps its last value.

Top module: `cal_corrector`

## Requirements
- R1: When `rst_n` is low, `out_valid` is 0 and `out_data` is 0.
- R2: The corrected value is x = sample·2^16 + (off_code − 8192)·6554, where 6554 = round(0.05·2^17). A higher offset code raises the result and a lower code reduces it.
- R3: The gain factor is g = 2^28 + (gain_code − 8192)·819, where 819 = round(0.025·2^15). The result before clamping is floor((x·g + 2^43) / 2^44).
- R4: Rounding goes to the nearest output step, and an exact half rounds up. With nominal gain and sample 100, offset code 8197 gives 101 and offset code 8196 gives 100.
- R5: A result above 16383 comes out as 16383.
- R6: A result below 0 comes out as 0.
- R7: `out_valid` equals the value `in_valid` had two cycles earlier, and results come out in the order the samples went in.
- R8: With both codes at 8192, `out_data` equals the input sample exactly.
- R9: When no valid sample leaves the first stage, `out_data` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Marks a sample on `in_sample` |
| in_sample | input | 14 | Unsigned raw sample code |
| off_code | input | 14 | Offset calibration data field, 0x2000 means no correction |
| gain_code | input | 14 | Gain calibration data field, 0x2000 means unity gain |
| out_valid | output | 1 | Marks a corrected result |
| out_data | output | 14 | Corrected, rounded and clamped result |

## Verification
The assertions assume that both calibration codes stay still while samples are in the pipeline. The offset code is used one cycle earlier than the gain code, and the identity check looks back two cycles at both. The bench respects this by letting the pipeline drain for several idle cycles before it changes either code. Samples are sent in back-to-back bursts and with gaps between them. This exercises both the latency check and the hold check.

// File: rtl/cal_corr_pkg.sv
package cal_corr_pkg;

  // Offset step, in sample LSBs scaled by 2^fb: 0.05 * 2^dw / 2^(cw-1).
  function automatic int off_step(input int dw, input int cw, input int fb);
    return ((1 << (dw - cw + 1 + fb)) * 5 + 50) / 100;
  endfunction

  // Gain step, scaled by 2^gb: 0.025 / 2^(cw-1).
  function automatic int gain_step(input int cw, input int gb);
    return ((1 << (gb - cw + 1)) * 25 + 500) / 1000;
  endfunction

endpackage

// File: rtl/cal_corr_offset.sv
module cal_corr_offset #(
  parameter int DW = 14,
  parameter int CW = 14,
  parameter int FB = 16,
  localparam int XW = DW + FB + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [DW-1:0]        in_sample,
  input  logic [CW-1:0]        off_code,
  output logic                 v1,
  output logic signed [XW-1:0] x1
);
  localparam int K = cal_corr_pkg::off_step(DW, CW, FB);
  localparam logic signed [XW-1:0] KS = XW'(K);

  function automatic logic signed [XW-1:0] corrected(input logic [DW-1:0] s,
                                                     input logic [CW-1:0] c);
    logic signed [CW:0]   d;
    logic signed [XW-1:0] base;
    d    = $signed({1'b0, c}) - $signed({2'b01, {(CW-1){1'b0}}});
    base = $signed(XW'({1'b0, s})) <<< FB;
    return base + XW'(d) * KS;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      x1 <= '0;
    end else begin
      v1 <= in_valid;
      if (in_valid) x1 <= corrected(in_sample, off_code);
    end
  end
endmodule

// File: rtl/cal_corr_gain.sv
module cal_corr_gain #(
  parameter int DW = 14,
  parameter int CW = 14,
  parameter int FB = 16,
  parameter int GB = 28,
  localparam int XW = DW + FB + 2,
  localparam int GW = GB + 2,
  localparam int PW = XW + GW,
  localparam int SH = FB + GB
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 v1,
  input  logic signed [XW-1:0] x1,
  input  logic [CW-1:0]        gain_code,
  output logic                 sat_hi,
  output logic                 sat_lo,
  output logic                 out_valid,
  output logic [DW-1:0]        out_data
);
  localparam int GK = cal_corr_pkg::gain_step(CW, GB);
  localparam logic signed [GW-1:0] GKS  = GW'(GK);
  localparam logic signed [GW-1:0] ONE  = GW'(1) <<< GB;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (SH - 1);
  localparam logic signed [PW-1:0] MAXV = (PW'(1) <<< DW) - PW'(1);

  function automatic logic signed [GW-1:0] factor(input logic [CW-1:0] c);
    logic signed [CW:0] d;
    d = $signed({1'b0, c}) - $signed({2'b01, {(CW-1){1'b0}}});
    return ONE + GW'(d) * GKS;
  endfunction

  function automatic logic signed [PW-1:0] scaled(input logic signed [XW-1:0] x,
                                                  input logic signed [GW-1:0] g);
    logic signed [PW-1:0] p;
    p = PW'(x) * PW'(g);
    return (p + HALF) >>> SH;
  endfunction

  logic signed [PW-1:0] r;
  logic [DW-1:0]        clamped;

  always_comb begin
    r       = scaled(x1, factor(gain_code));
    sat_lo  = r[PW-1];
    sat_hi  = !sat_lo && (r > MAXV);
    clamped = sat_lo ? '0 : (sat_hi ? '1 : r[DW-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= v1;
      if (v1) out_data <= clamped;
    end
  end
endmodule

// File: rtl/cal_corrector.sv
module cal_corrector #(
  parameter int DW = 14,
  parameter int CW = 14,
  parameter int FB = 16,
  parameter int GB = 28,
  localparam int XW = DW + FB + 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [DW-1:0] in_sample,
  input  logic [CW-1:0] off_code,
  input  logic [CW-1:0] gain_code,
  output logic          out_valid,
  output logic [DW-1:0] out_data
);
  logic                 v1;
  logic signed [XW-1:0] x1;
  logic                 sat_hi;
  logic                 sat_lo;

  cal_corr_offset #(.DW(DW), .CW(CW), .FB(FB)) u_off (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .off_code(off_code), .v1(v1), .x1(x1)
  );

  cal_corr_gain #(.DW(DW), .CW(CW), .FB(FB), .GB(GB)) u_gain (
    .clk(clk), .rst_n(rst_n), .v1(v1), .x1(x1), .gain_code(gain_code),
    .sat_hi(sat_hi), .sat_lo(sat_lo), .out_valid(out_valid), .out_data(out_data)
  );
endmodule

// File: rtl/cal_corrector_chk.sv
module cal_corrector_chk #(
  parameter int DW = 14,
  parameter int CW = 14
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic [DW-1:0] in_sample,
  input logic [CW-1:0] off_code,
  input logic [CW-1:0] gain_code,
  input logic          v1,
  input logic          sat_hi,
  input logic          sat_lo,
  input logic          out_valid,
  input logic [DW-1:0] out_data
);
  localparam logic [CW-1:0] MID = CW'(1) << (CW - 1);
  logic [1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else if (cnt != 2'd3) cnt <= cnt + 2'd1;
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= 2'd2) |-> (out_valid == $past(in_valid, 2))); // R7

  AST_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt >= 2'd2 && out_valid && $past(off_code, 2) == MID && $past(gain_code, 2) == MID
     && $past(gain_code, 1) == MID) |-> (out_data == $past(in_sample, 2))); // R8

  AST_CLAMP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && sat_hi) |=> (out_valid && out_data == {DW{1'b1}})); // R5

  AST_CLAMP_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (v1 && sat_lo) |=> (out_valid && out_data == '0)); // R6

  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !v1 |=> $stable(out_data)); // R9
endmodule

bind cal_corrector cal_corrector_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
  .off_code(off_code), .gain_code(gain_code), .v1(v1), .sat_hi(sat_hi),
  .sat_lo(sat_lo), .out_valid(out_valid), .out_data(out_data)
);

// File: tb/sim_cal_corrector.sv
module sim_cal_corrector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [13:0] in_sample = '0;
  logic [13:0] off_code = 14'h2000;
  logic [13:0] gain_code = 14'h2000;
  logic        out_valid;
  logic [13:0] out_data;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 0;
  bit running = 0;
  bit have_last = 0;
  int last_val = 0;

  int    q_val[$];
  int    q_cyc[$];
  string q_tag[$];

  cal_corrector u0 (.*);

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic int model(int s, int o, int g);
    longint x, f, p, r;
    x = longint'(s) * 65536 + longint'(o - 8192) * 6554;
    f = 268435456 + longint'(g - 8192) * 819;
    p = x * f;
    r = (p + (64'sd1 <<< 43)) >>> 44;
    if (r < 0) return 0;
    if (r > 16383) return 16383;
    return int'(r);
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic drive(int s, string tag);
    @(posedge clk); #1;
    in_valid  = 1'b1;
    in_sample = 14'(s);
    q_val.push_back(model(s, off_code, gain_code));
    q_cyc.push_back(cyc);
    q_tag.push_back(tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      in_valid  = 1'b0;
      in_sample = 14'(i * 37);
    end
  endtask

  task automatic set_cal(int o, int g);
    idle(4);
    off_code  = 14'(o);
    gain_code = 14'(g);
  endtask

  // monitor
  always @(negedge clk) begin
    if (running) begin
      if (out_valid) begin
        if (q_val.size() == 0) begin
          check("R7 unexpected out_valid", 1, 0);
        end else begin
          int e, c;
          string t;
          e = q_val.pop_front();
          c = q_cyc.pop_front();
          t = q_tag.pop_front();
          check(t, int'(out_data), e);
          check("R7 latency", cyc - c, 2);
          last_val  = int'(out_data);
          have_last = 1;
        end
      end else if (have_last) begin
        check("R9 hold", int'(out_data), last_val);
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset out_valid", int'(out_valid), 0);
    check("R1 reset out_data", int'(out_data), 0);
    rst_n = 1'b1;
    running = 1;

    // R8 nominal codes: identity, back to back
    drive(0, "R8 identity 0");
    drive(1, "R8 identity 1");
    drive(8191, "R8 identity 8191");
    drive(16383, "R8 identity 16383");
    drive(12345, "R8 identity 12345");
    idle(3);

    // R2 offset direction
    set_cal(8192 + 1000, 8192);
    drive(5000, "R2 positive offset code");
    idle(2);
    drive(7000, "R2 positive offset code gap");
    set_cal(8192 - 1000, 8192);
    drive(5000, "R2 negative offset code");

    // R4 rounding at the half step
    set_cal(8197, 8192);
    drive(100, "R4 half rounds up");
    set_cal(8196, 8192);
    drive(100, "R4 below half rounds down");
    set_cal(8187, 8192);
    drive(100, "R4 negative side rounding");

    // R3 gain extremes
    set_cal(8192, 0);
    drive(16000, "R3 minimum gain");
    drive(9000, "R3 minimum gain mid");
    set_cal(8192, 16383);
    drive(10000, "R3 maximum gain");
    set_cal(9000, 7000);
    drive(4321, "R3 mixed codes");

    // R5 / R6 clamping
    set_cal(16383, 16383);
    drive(16383, "R5 clamp high");
    drive(16300, "R5 clamp high 2");
    set_cal(0, 0);
    drive(10, "R6 clamp low");
    drive(0, "R6 clamp low zero");
    drive(900, "R6 near lower edge");

    // mixed random traffic
    for (int b = 0; b < 10; b++) begin
      set_cal($urandom_range(16383), $urandom_range(16383));
      for (int k = 0; k < 20; k++) begin
        drive($urandom_range(16383), "R3 random");
        if ($urandom_range(3) == 0) idle($urandom_range(2) + 1);
      end
    end
    idle(6);
    check("R7 all results delivered", q_val.size(), 0);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule